// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block pulls 32-bit commands out of a circular buffer in system memory and hands them to a downstream consumer. Software fills the ring and moves a write pointer forward. The engine chases that pointer with single-dword memory reads. Each dword that arrives is placed in a small prefetch FIFO and advances the read pointer. The pointer therefore always names the newest entry that has been fetched without error. Software may reuse that slot and may read the pointer at any moment.

Control goes through a four-word register port:
- address 0 holds the read pointer and its reset handshake;
- address 1 holds the write pointer;
- address 2 holds the run and interrupt-enable bits;
- address 3 holds the memory-error flag.

Stopping the engine and resetting the pointer both use a read-back handshake. The relevant bit only reports its new value once the hardware action is complete. A memory error drops the faulty dword and raises a sticky flag, which can drive an interrupt line.

Top module: `cmdring_dma`

## Requirements
- R1: After reset, all four registers read 0. The command stream, the memory request and the interrupt are all inactive.
- R2: Fetching happens while run (address 2, bit 1) is 1, the read pointer differs from the write pointer (address 1, bits 7:0) and the FIFO is not full.
  - The request address is base + 4 × ((read pointer + 1) mod 256).
  - A good response advances the read pointer (address 0, bits 7:0) by one.
  - Fetching stops once the read pointer equals the write pointer.
- R3: The ring has 256 entries. After the read pointer reaches 255, the next fetch targets the base address and the pointer wraps to 0.
- R4: Commands leave in ring order on a valid/ready stream. An offered command holds its value until it is accepted.
- R5: At most four commands wait in the prefetch FIFO. With the stream stalled, the read pointer runs at most four entries ahead of the consumer.
- R6: After software writes run = 0, the run bit keeps reading 1 while a memory read is outstanding. It reads 0 once the engine is idle, and no further request is issued.
- R7: While stopped, writing 1 to address 0, bit 15 does three things: the read pointer becomes 0, queued commands are discarded, and bit 15 reads back as 1. Writing 0 to bit 15 makes it read 0.
- R8: A pointer-reset write made while the run bit reads 1 is ignored. Bit 15 stays 0 and the pointer keeps its value.
- R9: A response flagged as an error does three things: it sets the error flag (address 3, bit 0), it drops the dword, and it leaves the read pointer unchanged. Writing 1 to that bit clears it.
- R10: The interrupt output is 1 exactly while the error flag is set and the interrupt enable (address 2, bit 0) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select (0 read ptr, 1 write ptr, 2 control, 3 status) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for the selected register |
| ring_base_i | input | ADDR_W | Byte address of ring entry 0 |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory read request accepted |
| mem_req_addr_o | output | ADDR_W | Byte address of the dword to read |
| mem_rsp_valid_i | input | 1 | Memory read response valid |
| mem_rsp_data_i | input | DATA_W | Memory read response data |
| mem_rsp_err_i | input | 1 | Response carries an error |
| cmd_valid_o | output | 1 | Command offered on the stream |
| cmd_ready_i | input | 1 | Consumer accepts the command |
| cmd_data_o | output | DATA_W | Command dword |
| irq_o | output | 1 | Memory-error interrupt |

## Verification
The assertions assume a memory that returns exactly one response for each accepted request and never returns a response unprompted. They also assume that a pointer reset is requested only through the register port, so it can never coincide with a fetch. The bench's memory model follows these rules. It keeps one request pending at a time and answers it after a fixed latency, or after a hold that the bench releases. Error responses are injected once per armed entry, so a retried fetch succeeds.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_WAIT = 2'd2
    } fetch_state_e;

    localparam logic [1:0] REG_RDPTR = 2'd0;
    localparam logic [1:0] REG_WRPTR = 2'd1;
    localparam logic [1:0] REG_CTRL  = 2'd2;
    localparam logic [1:0] REG_STAT  = 2'd3;

    localparam int RDPTR_RST_BIT = 15;
    localparam int CTRL_RUN_BIT  = 1;
    localparam int CTRL_IEN_BIT  = 0;
    localparam int STAT_ERR_BIT  = 0;

endpackage

// File: rtl/cmdring_fifo.sv
module cmdring_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic              full_o,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [DATA_W-1:0] out_data_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [IDX_W-1:0]             wr;
        logic [IDX_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic     pop;

    assign out_valid_o = (q.cnt != '0);
    assign out_data_o  = q.mem[q.rd];
    assign full_o      = (q.cnt == CNT_W'(DEPTH));
    assign pop         = out_valid_o && out_ready_i;

    always_comb begin
        d = q;
        if (flush_i) begin
            d.wr  = '0;
            d.rd  = '0;
            d.cnt = '0;
        end else begin
            if (push_i) begin
                d.mem[q.wr] = push_data_i;
                d.wr        = (q.wr == LAST) ? '0 : q.wr + 1'b1;
            end
            if (pop) begin
                d.rd = (q.rd == LAST) ? '0 : q.rd + 1'b1;
            end
            d.cnt = q.cnt + CNT_W'(push_i) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |-> !full_o);

    // R4
    out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i && !flush_i) |=> (out_valid_o && $stable(out_data_o)));

endmodule

// File: rtl/cmdring_fetch.sv
module cmdring_fetch
    import cmdring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PTR_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic [PTR_W-1:0]  wp_i,
    input  logic              fifo_full_i,
    input  logic              ptr_rst_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [DATA_W-1:0] mem_rsp_data_i,
    input  logic              mem_rsp_err_i,
    output logic              push_o,
    output logic [DATA_W-1:0] push_data_o,
    output logic              err_o,
    output logic              busy_o,
    output logic [PTR_W-1:0]  rp_o
);
    typedef struct packed {
        fetch_state_e      state;
        logic [PTR_W-1:0]  rp;
        logic [ADDR_W-1:0] addr;
    } fetch_st_t;

    fetch_st_t        q, d;
    logic [PTR_W-1:0] nxt;

    assign nxt             = q.rp + PTR_W'(1);
    assign mem_req_valid_o = (q.state == FS_REQ);
    assign mem_req_addr_o  = q.addr;
    assign busy_o          = (q.state != FS_IDLE);
    assign rp_o            = q.rp;
    assign push_data_o     = mem_rsp_data_i;

    always_comb begin
        d      = q;
        push_o = 1'b0;
        err_o  = 1'b0;
        unique case (q.state)
            FS_IDLE: begin
                if (ptr_rst_i) begin
                    d.rp = '0;
                end else if (run_i && (q.rp != wp_i) && !fifo_full_i) begin
                    d.state = FS_REQ;
                    d.addr  = base_i + ADDR_W'({nxt, 2'b00});
                end
            end
            FS_REQ: begin
                if (mem_req_ready_i) d.state = FS_WAIT;
            end
            FS_WAIT: begin
                if (mem_rsp_valid_i) begin
                    d.state = FS_IDLE;
                    if (mem_rsp_err_i) begin
                        err_o = 1'b1;
                    end else begin
                        push_o = 1'b1;
                        d.rp   = nxt;
                    end
                end
            end
            default: d.state = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{state: FS_IDLE, rp: '0, addr: '0};
        else         q <= d;
    end

    // R2
    req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

    // R6
    stop_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_req_valid_o) |-> $past(run_i));

    // R8
    rst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ptr_rst_i |-> (q.state == FS_IDLE));

    // R2
    rp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rp_o != $past(rp_o)) |-> ((rp_o == PTR_W'($past(rp_o) + 1'b1)) || (rp_o == '0)));

endmodule

// File: rtl/cmdring_regs.sv
module cmdring_regs
    import cmdring_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [15:0]      reg_wdata_i,
    output logic [15:0]      reg_rdata_o,
    input  logic             busy_i,
    input  logic [PTR_W-1:0] rp_i,
    input  logic             err_set_i,
    output logic             run_o,
    output logic [PTR_W-1:0] wp_o,
    output logic             ptr_rst_o,
    output logic             irq_o
);
    typedef struct packed {
        logic             run;
        logic             ien;
        logic             rst_done;
        logic             err;
        logic [PTR_W-1:0] wp;
    } regs_st_t;

    regs_st_t q, d;
    logic     run_rep;

    assign run_rep = q.run || busy_i;
    assign run_o   = q.run;
    assign wp_o    = q.wp;
    assign irq_o   = q.err && q.ien;

    always_comb begin
        d         = q;
        ptr_rst_o = 1'b0;
        if (reg_wr_i) begin
            unique case (reg_addr_i)
                REG_RDPTR: begin
                    if (!reg_wdata_i[RDPTR_RST_BIT]) begin
                        d.rst_done = 1'b0;
                    end else if (!run_rep) begin
                        ptr_rst_o  = 1'b1;
                        d.rst_done = 1'b1;
                    end
                end
                REG_WRPTR: d.wp = reg_wdata_i[PTR_W-1:0];
                REG_CTRL: begin
                    d.run = reg_wdata_i[CTRL_RUN_BIT];
                    d.ien = reg_wdata_i[CTRL_IEN_BIT];
                end
                REG_STAT: begin
                    if (reg_wdata_i[STAT_ERR_BIT]) d.err = 1'b0;
                end
                default: ;
            endcase
        end
        if (err_set_i) d.err = 1'b1;
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            REG_RDPTR: begin
                reg_rdata_o[RDPTR_RST_BIT] = q.rst_done;
                reg_rdata_o[PTR_W-1:0]     = rp_i;
            end
            REG_WRPTR: reg_rdata_o[PTR_W-1:0] = q.wp;
            REG_CTRL: begin
                reg_rdata_o[CTRL_RUN_BIT] = run_rep;
                reg_rdata_o[CTRL_IEN_BIT] = q.ien;
            end
            REG_STAT: reg_rdata_o[STAT_ERR_BIT] = q.err;
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata_i;

    // R9
    err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.err) |-> $past(err_set_i));

    // R7
    rst_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.rst_done) |-> (rp_i == '0));

endmodule

// File: rtl/cmdring_dma.sv
module cmdring_dma #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int PTR_W      = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o,
    input  logic [ADDR_W-1:0] ring_base_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [DATA_W-1:0] mem_rsp_data_i,
    input  logic              mem_rsp_err_i,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [DATA_W-1:0] cmd_data_o,
    output logic              irq_o
);
    logic              run;
    logic              busy;
    logic              ptr_rst;
    logic              err_set;
    logic              fifo_full;
    logic              push;
    logic [DATA_W-1:0] push_data;
    logic [PTR_W-1:0]  rp;
    logic [PTR_W-1:0]  wp;

    cmdring_regs #(.PTR_W(PTR_W)) i_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .busy_i      (busy),
        .rp_i        (rp),
        .err_set_i   (err_set),
        .run_o       (run),
        .wp_o        (wp),
        .ptr_rst_o   (ptr_rst),
        .irq_o       (irq_o)
    );

    cmdring_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) i_fetch (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .run_i           (run),
        .wp_i            (wp),
        .fifo_full_i     (fifo_full),
        .ptr_rst_i       (ptr_rst),
        .base_i          (ring_base_i),
        .mem_req_valid_o (mem_req_valid_o),
        .mem_req_ready_i (mem_req_ready_i),
        .mem_req_addr_o  (mem_req_addr_o),
        .mem_rsp_valid_i (mem_rsp_valid_i),
        .mem_rsp_data_i  (mem_rsp_data_i),
        .mem_rsp_err_i   (mem_rsp_err_i),
        .push_o          (push),
        .push_data_o     (push_data),
        .err_o           (err_set),
        .busy_o          (busy),
        .rp_o            (rp)
    );

    cmdring_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .flush_i     (ptr_rst),
        .push_i      (push),
        .push_data_i (push_data),
        .full_o      (fifo_full),
        .out_valid_o (cmd_valid_o),
        .out_ready_i (cmd_ready_i),
        .out_data_o  (cmd_data_o)
    );

endmodule

// File: tb/test_cmdring_dma.sv
module test_cmdring_dma;
    import cmdring_pkg::*;

    localparam logic [31:0] BASE = 32'h0004_0000;
    localparam int NVEC = 6;
    localparam logic [7:0] VEC_WP [NVEC] = '{8'd3, 8'd9, 8'd9, 8'd180, 8'd255, 8'd4};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [31:0] cmd_data;
    logic        irq;

    always #5 clk = ~clk;

    cmdring_dma i_cmdring_dma (
        .clk_i(clk), .rst_ni(rst_n),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .ring_base_i(BASE),
        .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready), .mem_req_addr_o(mem_req_addr),
        .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data), .mem_rsp_err_i(mem_rsp_err),
        .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_data_o(cmd_data),
        .irq_o(irq)
    );

    int n_tests = 0;
    int n_fail  = 0;

    function automatic logic [31:0] pat(int i);
        return 32'hC0DE_0000 + 32'(i & 255) * 32'h0000_0101;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // stream monitor: entries must arrive in ring order (R4)
    int exp_idx = 1;
    int n_cmds  = 0;
    always @(negedge clk) begin
        #3;
        if (rst_n && cmd_valid && cmd_ready) begin
            check("R4", "command order", cmd_data, pat(exp_idx));
            exp_idx = (exp_idx + 1) % 256;
            n_cmds++;
        end
    end

    // memory model: one pending read, fixed latency, optional hold and one-shot error
    logic        mem_hold = 1'b0;
    bit          pend = 0;
    int          cnt = 0;
    int          idx = 0;
    logic [31:0] req_addr = '0;
    int          n_reqs = 0;
    bit          err_armed = 0;
    int          err_idx = 0;
    bit          saw_base = 0;
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        if (pend) begin
            if (cnt > 0) cnt--;
            else if (!mem_hold) begin
                idx = int'((req_addr - BASE) >> 2) & 255;
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pat(idx);
                if (err_armed && idx == err_idx) begin
                    mem_rsp_err = 1'b1;
                    err_armed   = 0;
                end
                pend = 0;
            end
        end
        if (rst_n && mem_req_valid && !pend) begin
            pend     = 1;
            cnt      = 1;
            req_addr = mem_req_addr;
            n_reqs++;
            if (mem_req_addr == BASE) saw_base = 1;
        end
    end

    task automatic wr(logic [1:0] a, logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic poll(logic [1:0] a, logic [15:0] mask, logic [15:0] val, int limit, output bit ok);
        logic [15:0] v;
        ok = 0;
        for (int i = 0; i < limit; i++) begin
            rd(a, v);
            if ((v & mask) == val) begin
                ok = 1;
                break;
            end
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [15:0] v;
        bit          ok;
        int          c0;
        int          r0;
        int          prev;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(REG_RDPTR, v); check("R1", "read ptr reg", v, 16'h0000);
        rd(REG_WRPTR, v); check("R1", "write ptr reg", v, 16'h0000);
        rd(REG_CTRL, v);  check("R1", "control reg", v, 16'h0000);
        rd(REG_STAT, v);  check("R1", "status reg", v, 16'h0000);
        check("R1", "cmd_valid", cmd_valid, 0);
        check("R1", "mem_req_valid", mem_req_valid, 0);
        check("R1", "irq", irq, 0);

        // vector table: write pointer targets, including the wrap past 255
        wr(REG_CTRL, 16'h0002);
        prev = 0;
        for (int i = 0; i < NVEC; i++) begin
            c0 = n_cmds;
            saw_base = 0;
            wr(REG_WRPTR, {8'h00, VEC_WP[i]});
            poll(REG_RDPTR, 16'h00FF, {8'h00, VEC_WP[i]}, 2000, ok);
            repeat (8) @(negedge clk);
            check("R2", "read ptr reached write ptr", 32'(ok), 1);
            rd(REG_RDPTR, v); check("R2", "read ptr value", v, {8'h00, VEC_WP[i]});
            rd(REG_WRPTR, v); check("R2", "write ptr readback", v, {8'h00, VEC_WP[i]});
            check("R4", "commands delivered", n_cmds - c0, (int'(VEC_WP[i]) - prev + 256) % 256);
            if (int'(VEC_WP[i]) < prev) check("R3", "fetch from base after 255", 32'(saw_base), 1);
            prev = int'(VEC_WP[i]);
        end

        // R8 pointer reset ignored while running
        rd(REG_CTRL, v); check("R8", "run reads 1", v, 16'h0002);
        wr(REG_RDPTR, 16'h8000);
        rd(REG_RDPTR, v); check("R8", "reset ignored while running", v, 16'h0004);

        // R6 stop read-back with a read outstanding
        mem_hold = 1'b1;
        wr(REG_WRPTR, 16'h0007);
        for (int i = 0; i < 20 && !pend; i++) @(negedge clk);
        check("R6", "read became outstanding", 32'(pend), 1);
        wr(REG_CTRL, 16'h0000);
        for (int i = 0; i < 3; i++) begin
            rd(REG_CTRL, v); check("R6", "run still reads 1 while busy", v, 16'h0002);
        end
        r0 = n_reqs;
        mem_hold = 1'b0;
        poll(REG_CTRL, 16'h0002, 16'h0000, 20, ok);
        check("R6", "run reads 0 once idle", 32'(ok), 1);
        repeat (10) @(negedge clk);
        check("R6", "no request after stop", n_reqs - r0, 0);
        rd(REG_RDPTR, v); check("R6", "outstanding read landed", v, 16'h0005);

        // R5 back-pressure, then R7 flush by pointer reset
        cmd_ready = 1'b0;
        wr(REG_WRPTR, 16'd20);
        wr(REG_CTRL, 16'h0002);
        repeat (40) @(negedge clk);
        rd(REG_RDPTR, v); check("R5", "read ptr limited by FIFO", v, 16'h0009);
        check("R4", "stalled command held", cmd_data, pat(6));
        check("R4", "stalled command valid", cmd_valid, 1);
        wr(REG_CTRL, 16'h0000);
        poll(REG_CTRL, 16'h0002, 16'h0000, 20, ok);
        check("R6", "stop completes", 32'(ok), 1);
        wr(REG_RDPTR, 16'h8000);
        rd(REG_RDPTR, v); check("R7", "reset ack and pointer 0", v, 16'h8000);
        check("R7", "queued commands flushed", cmd_valid, 0);
        wr(REG_RDPTR, 16'h0000);
        rd(REG_RDPTR, v); check("R7", "reset bit clears", v, 16'h0000);
        exp_idx = 1;
        cmd_ready = 1'b1;
        c0 = n_cmds;
        wr(REG_WRPTR, 16'h0003);
        wr(REG_CTRL, 16'h0002);
        poll(REG_RDPTR, 16'h00FF, 16'h0003, 200, ok);
        repeat (8) @(negedge clk);
        check("R7", "refetch from entry 1", n_cmds - c0, 3);

        // R9 / R10 error with interrupt enabled
        err_idx = 5;
        err_armed = 1;
        wr(REG_CTRL, 16'h0003);
        c0 = n_cmds;
        wr(REG_WRPTR, 16'h0006);
        poll(REG_STAT, 16'h0001, 16'h0001, 100, ok);
        check("R9", "error flag set", 32'(ok), 1);
        check("R10", "irq with enable", irq, 1);
        rd(REG_RDPTR, v); check("R9", "pointer held on error", v, 16'h0004);
        poll(REG_RDPTR, 16'h00FF, 16'h0006, 200, ok);
        repeat (8) @(negedge clk);
        check("R9", "errored dword dropped then refetched", n_cmds - c0, 3);
        wr(REG_STAT, 16'h0001);
        rd(REG_STAT, v); check("R9", "flag clears on write 1", v, 16'h0000);
        check("R10", "irq drops with flag", irq, 0);

        // R10 error with interrupt disabled
        err_idx = 7;
        err_armed = 1;
        wr(REG_CTRL, 16'h0002);
        wr(REG_WRPTR, 16'h0008);
        poll(REG_STAT, 16'h0001, 16'h0001, 100, ok);
        check("R9", "second error flag", 32'(ok), 1);
        check("R10", "irq masked", irq, 0);
        wr(REG_STAT, 16'h0001);
        poll(REG_RDPTR, 16'h00FF, 16'h0008, 200, ok);
        check("R2", "final pointer", 32'(ok), 1);

        report();
        $finish;
    end

endmodule